// File: doc/BRIEF.md
# MDIO Management Register Slave

This block is the management end of a 10/100 Ethernet PHY. It runs on the management clock MDC and watches the bidirectional MDIO line. The line is split into a sampled input, a driven output and an output enable. Frames that carry the strapped 5-bit PHY address read or write a small set of 16-bit registers: control, status, two identifier words, the local ability advertisement, the partner ability word and an expansion word. Frames for any other address are followed to their end but leave no trace.

The control register drives plain configuration pins: isolate, loopback, collision test, speed, duplex and auto-negotiation enable. It also gives a one-cycle restart pulse. The status inputs come from the datapath and from the negotiation logic. Link state is held in a latch that goes low and stays low until the status word is read. The page-received event is held in a latch that goes high and clears when the expansion word is read. Every pin other than MDIO is a plain level or pulse with no handshake. The datapath and the negotiation arbitration sit outside this block.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted after at least 32 consecutive ones. It continues with the start bits 0 then 1, a 2-bit opcode (10 read, 01 write, any other value aborts), a 5-bit PHY address and a 5-bit register address, both MSB first. If the PHY address differs from `phy_addr`, the frame does not drive MDIO and does not change any register.
- R2: MDIO is sampled on the rising edge of MDC. On a read, `mdio_oe` stays low during the first turnaround bit and the block drives 0 during the second. It then drives D15 down to D0, each bit changing just after a rising edge, and releases the line after D0.
- R3: Register 0 (control) has these read/write fields: bit 14 loopback, bit 13 speed, bit 12 auto-negotiation enable, bit 10 isolate, bit 8 duplex and bit 7 collision test. Its other bits read 0. After reset it holds 0x3000, plus bit 10 when `phy_addr` is 0. Each field drives its output pin.
- R4: Writing register 0 with bit 15 set restores registers 0 and 4 to their reset values, and bit 15 reads back 0. Writing bit 9 (with bit 15 clear) pulses `an_restart_o` for one MDC cycle, and bit 9 reads back 0.
- R5: `isolate_o` is 1 out of reset exactly when `phy_addr` is 00000.
- R6: Register 1 (status) reads 0x7809, with `an_done_i` in bit 5 and the link latch in bit 2. Writes to it are ignored.
- R7: The link latch is cleared out of reset. Any cycle with `link_up_i` low clears it, and it stays cleared until a read of register 1. That read returns the latched value and then reloads the latch from `link_up_i`.
- R8: Register 2 reads OUI bits 21..6 (0x0181 for OUI 0x00606E). Register 3 reads {OUI[5:0], model[5:0], revision[3:0]} (0xB823 with the defaults model 2 and revision 3). Writes to both are ignored.
- R9: Register 4 (advertisement) has read/write ability bits 8..5, which reset to 1111. Bits 4..0 are a fixed selector of 00001 and the other bits read 0. The reset value is 0x01E1.
- R10: Register 5 returns `lp_ability_i`. In register 6, bit 0 is `lp_an_able_i` and bit 1 is a page latch. The latch is set by `page_rx_i` and cleared by a read of register 6. A new event on the same edge as that read leaves the latch set.
- R11: While collision test is set, `col_o` follows `tx_en_i`. Otherwise `col_o` is 0.
- R12: Register addresses 7 to 31 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address |
| mdio_i | input | 1 | Sampled MDIO line |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| link_up_i | input | 1 | Current link state |
| an_done_i | input | 1 | Auto-negotiation finished |
| page_rx_i | input | 1 | One-cycle page-received event |
| lp_an_able_i | input | 1 | Partner can negotiate |
| lp_ability_i | input | 16 | Partner ability word |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| col_o | output | 1 | Forced collision indication |
| loopback_o | output | 1 | Loopback control |
| speed_o | output | 1 | Speed select (1 = 100 Mb/s) |
| an_en_o | output | 1 | Auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle negotiation restart |
| isolate_o | output | 1 | Isolate the MII data path |
| duplex_o | output | 1 | Full duplex select |

## Verification
Two kinds of action can land on the same MDC edge: an incoming status event and the read that clears the latch holding it. The bench pulses `page_rx_i` during the first turnaround bit of a read of register 6, so the event and the clear-on-read happen on the same rising edge. It then expects the first read to show the old, clear value and the next read to show the page bit set. The link latch gets the matching treatment. A one-cycle drop of `link_up_i` must survive until the next status read, and that read must reload the latch so that the read after it shows the link up again.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST, S_HDR, S_TA1, S_TA2, S_DATA
  } frm_state_e;

  localparam logic [4:0] A_CTRL  = 5'd0;
  localparam logic [4:0] A_STAT  = 5'd1;
  localparam logic [4:0] A_ID_HI = 5'd2;
  localparam logic [4:0] A_ID_LO = 5'd3;
  localparam logic [4:0] A_ADV   = 5'd4;
  localparam logic [4:0] A_LPA   = 5'd5;
  localparam logic [4:0] A_EXP   = 5'd6;

  localparam int unsigned B_SRST  = 15;
  localparam int unsigned B_LOOP  = 14;
  localparam int unsigned B_SPEED = 13;
  localparam int unsigned B_ANEN  = 12;
  localparam int unsigned B_ISO   = 10;
  localparam int unsigned B_RSTRT = 9;
  localparam int unsigned B_DUP   = 8;
  localparam int unsigned B_COLT  = 7;

  localparam logic [15:0] CTRL_RW_MASK = 16'h7580;
  localparam logic [15:0] CTRL_BASE    = 16'h3000;
  localparam logic [3:0]  ADV_RST      = 4'hF;
  localparam logic [4:0]  ADV_SEL      = 5'b00001;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mdio_i,
  input  logic [4:0]  phy_addr,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_req,
  output logic        wr_en,
  output logic [4:0]  reg_addr,
  output logic [15:0] wr_data,
  input  logic [15:0] rd_data
);
  localparam int unsigned PW = $clog2(PRE_LEN + 1);
  localparam logic [PW-1:0] PRE_MAX = PW'(PRE_LEN);

  frm_state_e    state;
  logic [PW-1:0] pre_cnt;
  logic [3:0]    bcnt;
  logic [11:0]   hdr;
  logic [11:0]   hdr_next;
  logic [15:0]   shift;
  logic          is_rd;
  logic          hit;

  assign hdr_next = {hdr[10:0], mdio_i};
  assign reg_addr = hdr[4:0];
  assign rd_req   = (state == S_TA1) && is_rd && hit;
  assign wr_en    = (state == S_DATA) && !is_rd && hit && (bcnt == 4'd15);
  assign wr_data  = {shift[14:0], mdio_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PRE;
      pre_cnt <= '0;
      bcnt    <= '0;
      hdr     <= '0;
      shift   <= '0;
      is_rd   <= 1'b0;
      hit     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      case (state)
        S_PRE: begin
          if (mdio_i) begin
            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            pre_cnt <= '0;
            if (pre_cnt == PRE_MAX) state <= S_ST;
          end
        end
        S_ST: begin
          bcnt  <= '0;
          state <= mdio_i ? S_HDR : S_PRE;
        end
        S_HDR: begin
          hdr <= hdr_next;
          if (bcnt == 4'd11) begin
            hit   <= (hdr_next[9:5] == phy_addr);
            is_rd <= (hdr_next[11:10] == 2'b10);
            if (hdr_next[11:10] == 2'b10 || hdr_next[11:10] == 2'b01)
              state <= S_TA1;
            else
              state <= S_PRE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        S_TA1: begin
          state <= S_TA2;
          if (is_rd && hit) begin
            mdio_oe <= 1'b1;
            mdio_o  <= 1'b0;
            shift   <= rd_data;
          end
        end
        S_TA2: begin
          state <= S_DATA;
          bcnt  <= '0;
          if (is_rd && hit) begin
            mdio_o <= shift[15];
            shift  <= {shift[14:0], 1'b0};
          end
        end
        S_DATA: begin
          if (bcnt == 4'd15) begin
            state   <= S_PRE;
            pre_cnt <= '0;
            mdio_oe <= 1'b0;
          end else begin
            bcnt <= bcnt + 1'b1;
            if (is_rd && hit) begin
              mdio_o <= shift[15];
              shift  <= {shift[14:0], 1'b0};
            end
          end
          if (!is_rd) shift <= {shift[14:0], mdio_i};
        end
        default: state <= S_PRE;
      endcase
    end
  end

  assert_ta_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> (state == S_PRE));
  assert_drive_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (hit && is_rd));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [23:0] OUI   = 24'h00606E,
  parameter logic [5:0]  MODEL = 6'd2,
  parameter logic [3:0]  REV   = 4'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        rd_req,
  input  logic        wr_en,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        link_up_i,
  input  logic        an_done_i,
  input  logic        page_rx_i,
  input  logic        lp_an_able_i,
  input  logic [15:0] lp_ability_i,
  output logic        loopback_o,
  output logic        speed_o,
  output logic        an_en_o,
  output logic        isolate_o,
  output logic        duplex_o,
  output logic        coltest_o,
  output logic        an_restart_o
);
  logic [15:0] ctrl_q;
  logic [15:0] ctrl_default;
  logic [3:0]  adv_q;
  logic        link_lat;
  logic        page_lat;
  logic        wr_ctrl;
  logic        wr_adv;

  assign ctrl_default = CTRL_BASE | ((phy_addr == 5'd0) ? (16'd1 << B_ISO) : 16'd0);
  assign wr_ctrl      = wr_en && (reg_addr == A_CTRL);
  assign wr_adv       = wr_en && (reg_addr == A_ADV);

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_STAT:  rd_data = {1'b0, 4'b1111, 5'b0, an_done_i, 1'b0, 1'b1, link_lat, 1'b0, 1'b1};
      A_ID_HI: rd_data = OUI[21:6];
      A_ID_LO: rd_data = {OUI[5:0], MODEL, REV};
      A_ADV:   rd_data = {7'b0, adv_q, ADV_SEL};
      A_LPA:   rd_data = lp_ability_i;
      A_EXP:   rd_data = {14'b0, page_lat, lp_an_able_i};
      default: rd_data = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= ctrl_default;
      adv_q        <= ADV_RST;
      link_lat     <= 1'b0;
      page_lat     <= 1'b0;
      an_restart_o <= 1'b0;
    end else begin
      an_restart_o <= wr_ctrl && wr_data[B_RSTRT] && !wr_data[B_SRST];
      if (wr_ctrl) begin
        if (wr_data[B_SRST]) begin
          ctrl_q <= ctrl_default;
          adv_q  <= ADV_RST;
        end else begin
          ctrl_q <= wr_data & CTRL_RW_MASK;
        end
      end else if (wr_adv) begin
        adv_q <= wr_data[8:5];
      end
      if (rd_req && reg_addr == A_STAT) link_lat <= link_up_i;
      else                              link_lat <= link_lat & link_up_i;
      if (rd_req && reg_addr == A_EXP) page_lat <= page_rx_i;
      else                             page_lat <= page_lat | page_rx_i;
    end
  end

  assign loopback_o = ctrl_q[B_LOOP];
  assign speed_o    = ctrl_q[B_SPEED];
  assign an_en_o    = ctrl_q[B_ANEN];
  assign isolate_o  = ctrl_q[B_ISO];
  assign duplex_o   = ctrl_q[B_DUP];
  assign coltest_o  = ctrl_q[B_COLT];

  assert_link_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_i |=> !link_lat);
  assert_page_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    page_rx_i |=> page_lat);
  assert_restart_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_o |=> !an_restart_o);
  assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data[B_SRST]) |=> (!loopback_o && an_en_o && adv_q == ADV_RST));
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  parameter logic [23:0] OUI     = 24'h00606E,
  parameter logic [5:0]  MODEL   = 6'd2,
  parameter logic [3:0]  REV     = 4'd3
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        link_up_i,
  input  logic        an_done_i,
  input  logic        page_rx_i,
  input  logic        lp_an_able_i,
  input  logic [15:0] lp_ability_i,
  input  logic        tx_en_i,
  output logic        col_o,
  output logic        loopback_o,
  output logic        speed_o,
  output logic        an_en_o,
  output logic        an_restart_o,
  output logic        isolate_o,
  output logic        duplex_o
);
  logic        rd_req;
  logic        wr_en;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        coltest;

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .phy_addr(phy_addr),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_req(rd_req), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  mdio_regs #(.OUI(OUI), .MODEL(MODEL), .REV(REV)) u_regs (
    .clk(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .rd_req(rd_req),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .link_up_i(link_up_i), .an_done_i(an_done_i), .page_rx_i(page_rx_i),
    .lp_an_able_i(lp_an_able_i), .lp_ability_i(lp_ability_i),
    .loopback_o(loopback_o), .speed_o(speed_o), .an_en_o(an_en_o),
    .isolate_o(isolate_o), .duplex_o(duplex_o), .coltest_o(coltest),
    .an_restart_o(an_restart_o)
  );

  assign col_o = coltest & tx_en_i;

  assert_col_gate_R11: assert property (@(posedge mdc) disable iff (!rst_n)
    col_o |-> tx_en_i);
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;
  localparam time TCK = 10ns;
  localparam int NV = 16;
  // {write, reg, write data, expected read}
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd0, 16'h0000, 16'h3000},
    {1'b1, 5'd0, 16'h4180, 16'h0000},
    {1'b0, 5'd0, 16'h0000, 16'h4180},
    {1'b1, 5'd0, 16'h2A7F, 16'h0000},
    {1'b0, 5'd0, 16'h0000, 16'h2000},
    {1'b1, 5'd4, 16'hFFFF, 16'h0000},
    {1'b0, 5'd4, 16'h0000, 16'h01E1},
    {1'b1, 5'd4, 16'h0000, 16'h0000},
    {1'b0, 5'd4, 16'h0000, 16'h0001},
    {1'b0, 5'd2, 16'h0000, 16'h0181},
    {1'b0, 5'd3, 16'h0000, 16'hB823},
    {1'b1, 5'd2, 16'h1234, 16'h0000},
    {1'b0, 5'd2, 16'h0000, 16'h0181},
    {1'b0, 5'd5, 16'h0000, 16'hC5E1},
    {1'b1, 5'd9, 16'hFFFF, 16'h0000},
    {1'b0, 5'd9, 16'h0000, 16'h0000}
  };

  logic mdc = 1'b0, rst_n = 1'b0;
  logic [4:0] phy_addr = 5'd0;
  logic mdio_i = 1'b1;
  logic mdio_o, mdio_oe;
  logic link_up_i = 1'b1, an_done_i = 1'b1, page_rx_i = 1'b0, lp_an_able_i = 1'b1;
  logic [15:0] lp_ability_i = 16'hC5E1;
  logic tx_en_i = 1'b0;
  logic col_o, loopback_o, speed_o, an_en_o, an_restart_o, isolate_o, duplex_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCK/2) mdc = ~mdc;

  mdio_mgmt_slave dut_i (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up_i(link_up_i),
    .an_done_i(an_done_i), .page_rx_i(page_rx_i), .lp_an_able_i(lp_an_able_i),
    .lp_ability_i(lp_ability_i), .tx_en_i(tx_en_i), .col_o(col_o),
    .loopback_o(loopback_o), .speed_o(speed_o), .an_en_o(an_en_o),
    .an_restart_o(an_restart_o), .isolate_o(isolate_o), .duplex_o(duplex_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    for (int i = 0; i < 32; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    for (int i = 1; i >= 0; i--) drive_bit(op[i]);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(2'b01, phy, ra);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 15; i >= 0; i--) drive_bit(d[i]);
    @(negedge mdc);
    mdio_i = 1'b1;
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input bit pg,
                         output logic [15:0] v, output bit any_oe, output bit ta_ok);
    send_hdr(2'b10, phy, ra);
    any_oe = 0;
    @(negedge mdc);
    mdio_i = 1'b1;
    ta_ok = (mdio_oe === 1'b0);
    if (pg) page_rx_i = 1'b1;
    @(negedge mdc);
    page_rx_i = 1'b0;
    any_oe |= (mdio_oe === 1'b1);
    ta_ok &= (mdio_oe === 1'b1) && (mdio_o === 1'b0);
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      v[i] = mdio_o;
      any_oe |= (mdio_oe === 1'b1);
      ta_ok &= (mdio_oe === 1'b1);
    end
    @(negedge mdc);
    ta_ok &= (mdio_oe === 1'b0);
  endtask

  function automatic string tag_of(input logic [4:0] ra);
    case (ra)
      5'd0: return "R3";
      5'd2, 5'd3: return "R8";
      5'd4: return "R9";
      5'd5: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic rd_chk(input string tag, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] v;
    bit o, t;
    do_read(5'd3, ra, 1'b0, v, o, t);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [15:0] v;
    bit o, t;
    // R5: isolate at reset with address 0
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    chk("R5 isolate addr0", {15'b0, isolate_o}, 16'd1);
    do_read(5'd0, 5'd0, 1'b0, v, o, t);
    chk("R3 ctrl reset addr0", v, 16'h3400);
    chk("R2 turnaround/release", {15'b0, t}, 16'd1);
    rst_n = 1'b0;
    phy_addr = 5'd3;
    repeat (2) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    chk("R5 isolate addr3", {15'b0, isolate_o}, 16'd0);
    chk("R3 reset outputs", {12'b0, speed_o, an_en_o, duplex_o, loopback_o}, 16'b1100);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][37]) do_write(5'd3, VEC[k][36:32], VEC[k][31:16]);
      else rd_chk(tag_of(VEC[k][36:32]), VEC[k][36:32], VEC[k][15:0]);
    end

    // R4 restart pulse and soft reset
    do_write(5'd3, 5'd0, 16'h1200);
    chk("R4 restart pulse", {15'b0, an_restart_o}, 16'd1);
    @(negedge mdc);
    chk("R4 restart one cycle", {15'b0, an_restart_o}, 16'd0);
    rd_chk("R4 restart reads 0", 5'd0, 16'h1000);
    do_write(5'd3, 5'd0, 16'h4180);
    chk("R3 loopback/duplex pins", {14'b0, loopback_o, duplex_o}, 16'b11);
    do_write(5'd3, 5'd4, 16'h0000);
    do_write(5'd3, 5'd0, 16'h8000);
    rd_chk("R4 soft reset ctrl", 5'd0, 16'h3000);
    rd_chk("R4 soft reset adv", 5'd4, 16'h01E1);
    chk("R4 loopback cleared", {15'b0, loopback_o}, 16'd0);

    // R11 collision test
    do_write(5'd3, 5'd0, 16'h0080);
    tx_en_i = 1'b1;
    @(negedge mdc);
    chk("R11 col on", {15'b0, col_o}, 16'd1);
    tx_en_i = 1'b0;
    @(negedge mdc);
    chk("R11 col follows", {15'b0, col_o}, 16'd0);
    do_write(5'd3, 5'd0, 16'h0000);
    tx_en_i = 1'b1;
    @(negedge mdc);
    chk("R11 col off", {15'b0, col_o}, 16'd0);
    tx_en_i = 1'b0;

    // R1 other PHY address
    do_write(5'd7, 5'd0, 16'h4000);
    chk("R1 foreign write pin", {15'b0, loopback_o}, 16'd0);
    rd_chk("R1 foreign write reg", 5'd0, 16'h0000);
    do_read(5'd7, 5'd0, 1'b0, v, o, t);
    chk("R1 foreign read no drive", {15'b0, o}, 16'd0);

    // R6 / R7 status and link latch
    rd_chk("R7 latch starts low", 5'd1, 16'h7829);
    rd_chk("R6 status link up", 5'd1, 16'h782D);
    @(negedge mdc);
    link_up_i = 1'b0;
    @(negedge mdc);
    link_up_i = 1'b1;
    rd_chk("R7 drop held", 5'd1, 16'h7829);
    rd_chk("R7 reload on read", 5'd1, 16'h782D);
    do_write(5'd3, 5'd1, 16'h0000);
    rd_chk("R6 write ignored", 5'd1, 16'h782D);

    // R10 page latch, including event on the reading edge
    page_rx_i = 1'b1;
    @(negedge mdc);
    page_rx_i = 1'b0;
    rd_chk("R10 page set", 5'd6, 16'h0003);
    rd_chk("R10 page cleared", 5'd6, 16'h0001);
    do_read(5'd3, 5'd6, 1'b1, v, o, t);
    chk("R10 collide read old", v, 16'h0001);
    rd_chk("R10 collide kept", 5'd6, 16'h0003);
    rd_chk("R10 collide cleared", 5'd6, 16'h0001);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mdc);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule